// File: doc/BRIEF.md
# Banked Execution-Context Switcher

This block keeps a bank of execution contexts for a processor with a small number of execution states (four by default). Each state has three banked words: a program word, a status word and an interrupt-enable mask. All states share one interrupt-flag vector, which the block receives as an input. The block also holds the live machine registers: current state number, program address, condition code, program mask, length code, protection key, decimal-mode bit and user-mode bit.

The block carries out two commands. The first is a privileged state transfer. It saves the program word of the state being left, with the new branch address in it. It then decides whether the requested state has an enabled pending interrupt. If one is pending, the block does not move into that state: it writes the requested state number into that state's status word and raises a redirect strobe, so the automatic-interrupt logic outside can take over. If nothing is pending, or if the command carries its test bit, the block loads the target's context into the live registers.

The second command is a supervisor-call capture. It writes the call's two 4-bit register fields into the low byte of the current state's status word. A configuration write port lets the surrounding core initialise the banked words, and a read port with one cycle of latency returns all three words of any state.

Top module: `ctx_switcher`

## Requirements
- R1: After synchronous reset the live state is 0 and the live address, flags and strobes are 0. Every banked word reads back 0, so every state starts in supervisor mode.
- R2: A transfer requested while bit 15 (user mode) of the current state's status word is 1 raises `priv_viol` for one cycle. It raises no `done`, changes no banked word and changes no live register.
- R3: An accepted transfer stores {length[1:0], cc[1:0], mask[3:0], address[AW-1:0]} into the program word of the state being left. The length sits in bits AW+7:AW+6, the cc in AW+5:AW+4, the program mask in AW+3:AW and the address in AW-1:0.
- R4: With the test bit clear, if the target's enable mask ANDed with `int_flags` is nonzero, the target's status bits 9:8 become the target number and all its other status bits keep their values. `intr_redirect` pulses together with `done`, and the live registers are left unchanged.
- R5: With the test bit clear and no enabled flag set for the target, the transfer completes into the target.
- R6: With the test bit set, the transfer completes into the target whatever the flags are.
- R7: A completed transfer sets the live state to the target. Live address, cc, program mask and length come from the target's program word. The protection key comes from status bits 13:10, the decimal bit from status bit 14 and the user-mode bit from status bit 15.
- R8: A transfer whose target is the current state restores the word just saved: the new address, cc and program mask.
- R9: A supervisor call taken in idle writes its 8 fields into status bits 7:0 of the current state and keeps bits 15:8. A supervisor call raised while a transfer is in progress is ignored.
- R10: Each accepted transfer gives exactly one `done` pulse, one cycle wide.
- R11: Configuration writes taken in idle land in the selected word: select 0 is the program word, 1 the status word and 2 the mask. The read port returns all three words of `rd_state` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Start a state transfer (sampled in idle) |
| xfer_target | input | SIDW | Requested state number |
| xfer_addr | input | AW | Branch address saved for the state being left |
| xfer_test | input | 1 | Skip the pending-interrupt check |
| svc_req | input | 1 | Supervisor-call capture (sampled in idle) |
| svc_fields | input | 8 | The two 4-bit register fields of the call |
| exec_ilc | input | 2 | Length code of the last executed instruction |
| exec_cc | input | 2 | Current condition code |
| exec_pmask | input | 4 | Current program mask |
| int_flags | input | IW | Shared interrupt-flag vector |
| cfg_we | input | 1 | Banked-word write strobe (idle only) |
| cfg_sel | input | 2 | 0 program word, 1 status, 2 mask |
| cfg_state | input | SIDW | State whose word is written |
| cfg_data | input | AW+8 | Write data, low bits used for status and mask |
| rd_state | input | SIDW | State read on the read port |
| rd_pc | output | AW+8 | Program word of `rd_state` |
| rd_status | output | 16 | Status word of `rd_state` |
| rd_mask | output | IW | Enable mask of `rd_state` |
| live_state | output | SIDW | Live state number |
| live_pc | output | AW | Live program address |
| live_cc | output | 2 | Live condition code |
| live_pmask | output | 4 | Live program mask |
| live_ilc | output | 2 | Live length code |
| live_key | output | 4 | Live protection key |
| live_dec | output | 1 | Live decimal-mode bit |
| live_user | output | 1 | Live user-mode bit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Transfer finished (one cycle) |
| intr_redirect | output | 1 | Transfer diverted to interrupt handling |
| req_state | output | SIDW | State number of the last accepted transfer |
| priv_viol | output | 1 | Transfer refused for lack of privilege |

## Verification
The bench targets a transfer whose target is the current state. A design that reads the target before the save has landed would restore the stale address. It also drives a pending check whose mask and flags overlap in only one bit; a design that tests the wrong bank or ignores the test bit would redirect when it should complete, or complete when it should redirect. A refused transfer from a user-mode state is followed by reads of the banked words, which catches a design that saves before it checks privilege. A supervisor call raised mid-transfer is followed by a read of the status word, which catches a design that accepts commands while busy.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;
  localparam int ST_W      = 16;
  localparam int SVC_LSB   = 0;
  localparam int ID_LSB    = 8;
  localparam int ID_W      = 2;
  localparam int KEY_LSB   = 10;
  localparam int DEC_BIT   = 14;
  localparam int USER_BIT  = 15;
  localparam int CTL_W     = 8;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SAVE, SQ_TEST, SQ_CHECK,
    SQ_RESTORE, SQ_REDIRECT, SQ_DONE, SQ_SVC
  } seq_t;

  typedef struct packed {
    logic [1:0] ilc;
    logic [1:0] cc;
    logic [3:0] pmask;
  } pctl_t;
endpackage

// File: rtl/ctxsw_bank.sv
module ctxsw_bank #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [W-1:0]    wdata,
  input  logic [IDXW-1:0] ra_addr,
  output logic [W-1:0]    ra_data,
  input  logic [IDXW-1:0] rb_addr,
  output logic [W-1:0]    rb_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_data <= '0;
      rb_data <= '0;
    end else begin
      ra_data <= mem[ra_addr];
      rb_data <= mem[rb_addr];
    end
  end
endmodule

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
  import ctxsw_pkg::*;
#(
  parameter int NSTATE = 4,
  parameter int AW     = 24,
  parameter int IW     = 16,
  localparam int SIDW  = (NSTATE > 1) ? $clog2(NSTATE) : 1,
  localparam int PCW   = AW + CTL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xfer_req,
  input  logic [SIDW-1:0] xfer_target,
  input  logic [AW-1:0]   xfer_addr,
  input  logic            xfer_test,
  input  logic            svc_req,
  input  logic [7:0]      svc_fields,
  input  logic [1:0]      exec_ilc,
  input  logic [1:0]      exec_cc,
  input  logic [3:0]      exec_pmask,
  input  logic [IW-1:0]   int_flags,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [SIDW-1:0] cfg_state,
  input  logic [PCW-1:0]  cfg_data,
  input  logic [PCW-1:0]  pc_rd,
  input  logic [ST_W-1:0] st_rd,
  input  logic [IW-1:0]   mk_rd,
  output logic [SIDW-1:0] rd_addr,
  output logic            pc_we,
  output logic [SIDW-1:0] pc_waddr,
  output logic [PCW-1:0]  pc_wdata,
  output logic            st_we,
  output logic [SIDW-1:0] st_waddr,
  output logic [ST_W-1:0] st_wdata,
  output logic            mk_we,
  output logic [SIDW-1:0] mk_waddr,
  output logic [IW-1:0]   mk_wdata,
  output logic [SIDW-1:0] live_state,
  output logic [AW-1:0]   live_pc,
  output logic [1:0]      live_cc,
  output logic [3:0]      live_pmask,
  output logic [1:0]      live_ilc,
  output logic [3:0]      live_key,
  output logic            live_dec,
  output logic            live_user,
  output logic            busy,
  output logic            done,
  output logic            intr_redirect,
  output logic [SIDW-1:0] req_state,
  output logic            priv_viol
);
  seq_t            sq;
  logic [AW-1:0]   addr_q;
  logic            test_q;
  pctl_t           ctl_q;
  logic [7:0]      svc_q;
  logic            redir_q;
  logic            cfg_go;
  logic            pending;
  pctl_t           tgt_ctl;

  assign cfg_go  = (sq == SQ_IDLE) && !xfer_req && !svc_req && cfg_we;
  assign pending = |(mk_rd & int_flags);
  assign tgt_ctl = pctl_t'(pc_rd[PCW-1:AW]);
  assign rd_addr = (sq == SQ_IDLE) ? live_state : req_state;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq         <= SQ_IDLE;
      addr_q     <= '0;
      test_q     <= 1'b0;
      ctl_q      <= '0;
      svc_q      <= '0;
      redir_q    <= 1'b0;
      req_state  <= '0;
      priv_viol  <= 1'b0;
      live_state <= '0;
      live_pc    <= '0;
      live_cc    <= '0;
      live_pmask <= '0;
      live_ilc   <= '0;
      live_key   <= '0;
      live_dec   <= 1'b0;
      live_user  <= 1'b0;
    end else begin
      priv_viol <= 1'b0;
      case (sq)
        SQ_IDLE: begin
          if (xfer_req) begin
            req_state <= xfer_target;
            addr_q    <= xfer_addr;
            test_q    <= xfer_test;
            ctl_q     <= '{ilc: exec_ilc, cc: exec_cc, pmask: exec_pmask};
            sq        <= SQ_SAVE;
          end else if (svc_req) begin
            svc_q <= svc_fields;
            sq    <= SQ_SVC;
          end
        end
        SQ_SVC: sq <= SQ_IDLE;
        SQ_SAVE: begin
          if (st_rd[USER_BIT]) begin
            priv_viol <= 1'b1;
            sq        <= SQ_IDLE;
          end else begin
            sq <= SQ_TEST;
          end
        end
        SQ_TEST: begin
          redir_q <= 1'b0;
          sq      <= test_q ? SQ_RESTORE : SQ_CHECK;
        end
        SQ_CHECK: sq <= pending ? SQ_REDIRECT : SQ_RESTORE;
        SQ_RESTORE: begin
          live_state <= req_state;
          live_pc    <= pc_rd[AW-1:0];
          live_cc    <= tgt_ctl.cc;
          live_pmask <= tgt_ctl.pmask;
          live_ilc   <= tgt_ctl.ilc;
          live_key   <= st_rd[KEY_LSB +: 4];
          live_dec   <= st_rd[DEC_BIT];
          live_user  <= st_rd[USER_BIT];
          sq         <= SQ_DONE;
        end
        SQ_REDIRECT: begin
          redir_q <= 1'b1;
          sq      <= SQ_DONE;
        end
        SQ_DONE: sq <= SQ_IDLE;
        default: sq <= SQ_IDLE;
      endcase
    end
  end

  // Register-file writes: at most one per array per cycle.
  always_comb begin
    pc_we    = cfg_go && (cfg_sel == 2'd0);
    pc_waddr = cfg_state;
    pc_wdata = cfg_data;
    if (sq == SQ_SAVE && !st_rd[USER_BIT]) begin
      pc_we    = 1'b1;
      pc_waddr = live_state;
      pc_wdata = {ctl_q, addr_q};
    end
  end

  always_comb begin
    st_we    = cfg_go && (cfg_sel == 2'd1);
    st_waddr = cfg_state;
    st_wdata = cfg_data[ST_W-1:0];
    if (sq == SQ_SVC) begin
      st_we    = 1'b1;
      st_waddr = live_state;
      st_wdata = {st_rd[ST_W-1:8], svc_q};
    end else if (sq == SQ_REDIRECT) begin
      st_we    = 1'b1;
      st_waddr = req_state;
      st_wdata = st_rd;
      st_wdata[ID_LSB +: ID_W] = ID_W'(req_state);
    end
  end

  assign mk_we    = cfg_go && (cfg_sel == 2'd2);
  assign mk_waddr = cfg_state;
  assign mk_wdata = cfg_data[IW-1:0];

  assign busy          = (sq != SQ_IDLE);
  assign done          = (sq == SQ_DONE);
  assign intr_redirect = (sq == SQ_DONE) && redir_q;
endmodule

// File: rtl/ctx_switcher.sv
module ctx_switcher
  import ctxsw_pkg::*;
#(
  parameter int NSTATE = 4,
  parameter int AW     = 24,
  parameter int IW     = 16,
  localparam int SIDW  = (NSTATE > 1) ? $clog2(NSTATE) : 1,
  localparam int PCW   = AW + CTL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xfer_req,
  input  logic [SIDW-1:0] xfer_target,
  input  logic [AW-1:0]   xfer_addr,
  input  logic            xfer_test,
  input  logic            svc_req,
  input  logic [7:0]      svc_fields,
  input  logic [1:0]      exec_ilc,
  input  logic [1:0]      exec_cc,
  input  logic [3:0]      exec_pmask,
  input  logic [IW-1:0]   int_flags,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [SIDW-1:0] cfg_state,
  input  logic [PCW-1:0]  cfg_data,
  input  logic [SIDW-1:0] rd_state,
  output logic [PCW-1:0]  rd_pc,
  output logic [ST_W-1:0] rd_status,
  output logic [IW-1:0]   rd_mask,
  output logic [SIDW-1:0] live_state,
  output logic [AW-1:0]   live_pc,
  output logic [1:0]      live_cc,
  output logic [3:0]      live_pmask,
  output logic [1:0]      live_ilc,
  output logic [3:0]      live_key,
  output logic            live_dec,
  output logic            live_user,
  output logic            busy,
  output logic            done,
  output logic            intr_redirect,
  output logic [SIDW-1:0] req_state,
  output logic            priv_viol
);
  logic [SIDW-1:0] rd_addr;
  logic            pc_we, st_we, mk_we;
  logic [SIDW-1:0] pc_waddr, st_waddr, mk_waddr;
  logic [PCW-1:0]  pc_wdata, pc_rd;
  logic [ST_W-1:0] st_wdata, st_rd;
  logic [IW-1:0]   mk_wdata, mk_rd;

  ctxsw_bank #(.DEPTH(NSTATE), .W(PCW)) u_pc_bank (
    .clk(clk), .rst(rst), .we(pc_we), .waddr(pc_waddr), .wdata(pc_wdata),
    .ra_addr(rd_addr), .ra_data(pc_rd), .rb_addr(rd_state), .rb_data(rd_pc));

  ctxsw_bank #(.DEPTH(NSTATE), .W(ST_W)) u_st_bank (
    .clk(clk), .rst(rst), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .ra_addr(rd_addr), .ra_data(st_rd), .rb_addr(rd_state), .rb_data(rd_status));

  ctxsw_bank #(.DEPTH(NSTATE), .W(IW)) u_mk_bank (
    .clk(clk), .rst(rst), .we(mk_we), .waddr(mk_waddr), .wdata(mk_wdata),
    .ra_addr(rd_addr), .ra_data(mk_rd), .rb_addr(rd_state), .rb_data(rd_mask));

  ctxsw_seq #(.NSTATE(NSTATE), .AW(AW), .IW(IW)) u_seq (
    .clk(clk), .rst(rst),
    .xfer_req(xfer_req), .xfer_target(xfer_target), .xfer_addr(xfer_addr),
    .xfer_test(xfer_test), .svc_req(svc_req), .svc_fields(svc_fields),
    .exec_ilc(exec_ilc), .exec_cc(exec_cc), .exec_pmask(exec_pmask),
    .int_flags(int_flags), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_state(cfg_state), .cfg_data(cfg_data),
    .pc_rd(pc_rd), .st_rd(st_rd), .mk_rd(mk_rd), .rd_addr(rd_addr),
    .pc_we(pc_we), .pc_waddr(pc_waddr), .pc_wdata(pc_wdata),
    .st_we(st_we), .st_waddr(st_waddr), .st_wdata(st_wdata),
    .mk_we(mk_we), .mk_waddr(mk_waddr), .mk_wdata(mk_wdata),
    .live_state(live_state), .live_pc(live_pc), .live_cc(live_cc),
    .live_pmask(live_pmask), .live_ilc(live_ilc), .live_key(live_key),
    .live_dec(live_dec), .live_user(live_user), .busy(busy), .done(done),
    .intr_redirect(intr_redirect), .req_state(req_state),
    .priv_viol(priv_viol));
endmodule

// File: rtl/ctx_switcher_chk.sv
module ctx_switcher_chk #(
  parameter int NSTATE = 4,
  parameter int AW     = 24,
  localparam int SIDW  = (NSTATE > 1) ? $clog2(NSTATE) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic            intr_redirect,
  input logic            priv_viol,
  input logic [SIDW-1:0] live_state,
  input logic [AW-1:0]   live_pc,
  input logic [SIDW-1:0] req_state
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R2
  viol_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    priv_viol |=> !priv_viol);

  // R2
  viol_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    priv_viol |-> (!done && !busy && $stable(live_state) && $stable(live_pc)));

  // R4
  redirect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    intr_redirect |-> (done && $stable(live_state) && $stable(live_pc)));

  // R7
  restore_state_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !intr_redirect) |-> (live_state == req_state));
endmodule

bind ctx_switcher ctx_switcher_chk #(.NSTATE(NSTATE), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .intr_redirect(intr_redirect), .priv_viol(priv_viol),
  .live_state(live_state), .live_pc(live_pc), .req_state(req_state));

// File: tb/ctx_switcher_test.sv
`timescale 1ns/1ps
module ctx_switcher_test;
  localparam int AW = 24, IW = 16, PCW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic xfer_req = 0, xfer_test = 0, svc_req = 0, cfg_we = 0;
  logic [1:0] xfer_target = 0, cfg_sel = 0, cfg_state = 0, rd_state = 0;
  logic [AW-1:0] xfer_addr = 0;
  logic [7:0] svc_fields = 0;
  logic [1:0] exec_ilc = 0, exec_cc = 0;
  logic [3:0] exec_pmask = 0;
  logic [IW-1:0] int_flags = 0;
  logic [PCW-1:0] cfg_data = 0, rd_pc;
  logic [15:0] rd_status;
  logic [IW-1:0] rd_mask;
  logic [1:0] live_state, live_cc, live_ilc, req_state;
  logic [AW-1:0] live_pc;
  logic [3:0] live_pmask, live_key;
  logic live_dec, live_user, busy, done, intr_redirect, priv_viol;

  always #4 clk = ~clk;

  ctx_switcher uut (.*);

  typedef struct packed {
    logic viol; logic redir; logic [1:0] st; logic [1:0] req;
    logic [AW-1:0] pc; logic [1:0] ilc; logic [1:0] cc; logic [3:0] pm;
    logic [3:0] key; logic dec; logic user;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [PCW-1:0] m_pc [4];
  logic [15:0]    m_st [4];
  logic [IW-1:0]  m_mk [4];
  exp_t m_live;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops an expected item at every completion or refusal.
  always @(negedge clk) begin
    if (!rst && (done || priv_viol)) begin
      if (q.size() == 0) begin
        check("R10 unexpected completion", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check("R2 violation strobe", {31'd0, priv_viol}, {31'd0, e.viol});
        check("R4/R5 redirect strobe", {31'd0, intr_redirect}, {31'd0, e.redir});
        check("R7 live state", {30'd0, live_state}, {30'd0, e.st});
        check("R7 live address", {8'd0, live_pc}, {8'd0, e.pc});
        if (!e.viol) begin
          check("R10 done", {31'd0, done}, 32'd1);
          check("R4 req state", {30'd0, req_state}, {30'd0, e.req});
          check("R7 cc/mask/len", {24'd0, live_ilc, live_cc, live_pmask},
                {24'd0, e.ilc, e.cc, e.pm});
          check("R7 key/dec/user", {26'd0, live_key, live_dec, live_user},
                {26'd0, e.key, e.dec, e.user});
        end
      end
    end
  end

  task automatic cfg_wr(logic [1:0] sel, logic [1:0] s, logic [PCW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_state = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    if (sel == 0) m_pc[s] = d;
    else if (sel == 1) m_st[s] = d[15:0];
    else m_mk[s] = d[IW-1:0];
  endtask

  task automatic rd_chk(logic [1:0] s, string tag);
    @(negedge clk);
    rd_state = s;
    @(negedge clk);
    check({tag, " program word"}, rd_pc, m_pc[s]);
    check({tag, " status word"}, {16'd0, rd_status}, {16'd0, m_st[s]});
    check({tag, " mask"}, {16'd0, rd_mask}, {16'd0, m_mk[s]});
  endtask

  task automatic do_xfer(logic [1:0] t, logic [AW-1:0] a, logic tb,
                         logic [1:0] il, logic [1:0] c, logic [3:0] pm, bit poke);
    exp_t e;
    e = m_live;
    e.viol = 0; e.redir = 0; e.req = t;
    if (m_st[m_live.st][15]) begin
      e.viol = 1;
    end else begin
      m_pc[m_live.st] = {il, c, pm, a};
      if (!tb && ((m_mk[t] & int_flags) != 0)) begin
        e.redir = 1;
        m_st[t][9:8] = t;
      end else begin
        e.st = t; e.pc = m_pc[t][AW-1:0];
        e.ilc = m_pc[t][31:30]; e.cc = m_pc[t][29:28]; e.pm = m_pc[t][27:24];
        e.key = m_st[t][13:10]; e.dec = m_st[t][14]; e.user = m_st[t][15];
      end
      m_live = e;
    end
    q.push_back(e);
    @(negedge clk);
    xfer_req = 1; xfer_target = t; xfer_addr = a; xfer_test = tb;
    exec_ilc = il; exec_cc = c; exec_pmask = pm;
    @(negedge clk);
    xfer_req = 0;
    if (poke) begin
      svc_req = 1; svc_fields = 8'h55;
      @(negedge clk);
      svc_req = 0;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_pc[i] = 0; m_st[i] = 0; m_mk[i] = 0; end
    m_live = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 live state", {30'd0, live_state}, 32'd0);
    check("R1 live address", {8'd0, live_pc}, 32'd0);
    check("R1 strobes", {28'd0, busy, done, priv_viol, live_user}, 32'd0);
    rd_chk(2'd0, "R1 reset bank");

    // R11 configuration
    cfg_wr(1, 0, 32'h0C00);
    cfg_wr(1, 1, 32'h5400);
    cfg_wr(1, 2, 32'h9C00);
    cfg_wr(1, 3, 32'h2400);
    cfg_wr(2, 1, 32'h0001);
    cfg_wr(2, 3, 32'h00F0);
    cfg_wr(0, 1, {2'd0, 2'd2, 4'hA, 24'h001000});
    cfg_wr(0, 2, {2'd0, 2'd3, 4'h3, 24'h002000});
    cfg_wr(0, 3, {2'd0, 2'd1, 4'h6, 24'h003000});
    rd_chk(2'd3, "R11 config read");

    // R5 no pending, R9 call during busy ignored, R3 save
    int_flags = 16'h0000;
    do_xfer(2'd1, 24'h000123, 0, 2'd1, 2'd1, 4'h5, 1);
    rd_chk(2'd0, "R3 R9 saved state 0");

    // R4 pending in target: redirect
    int_flags = 16'h0010;
    do_xfer(2'd3, 24'h000456, 0, 2'd2, 2'd2, 4'h9, 0);
    rd_chk(2'd3, "R4 identifier field");
    rd_chk(2'd1, "R3 saved state 1");

    // R6 test bit overrides pending
    do_xfer(2'd3, 24'h000456, 1, 2'd2, 2'd2, 4'h9, 0);

    // R8 self transfer
    int_flags = 16'hFFFF;
    do_xfer(2'd3, 24'h000777, 1, 2'd3, 2'd3, 4'hF, 0);

    // R5 flags present but none enabled for target
    do_xfer(2'd2, 24'h000888, 0, 2'd0, 2'd1, 4'h2, 0);

    // R2 user-mode state refused
    do_xfer(2'd0, 24'h000999, 1, 2'd1, 2'd1, 4'h1, 0);
    rd_chk(2'd2, "R2 bank untouched");
    rd_chk(2'd0, "R2 target untouched");

    // R9 supervisor call capture
    @(negedge clk);
    svc_req = 1; svc_fields = 8'hAB;
    @(negedge clk);
    svc_req = 0;
    m_st[2][7:0] = 8'hAB;
    repeat (3) @(negedge clk);
    rd_chk(2'd2, "R9 call fields");
    check("R9 no done after call", {31'd0, done}, 32'd0);

    check("R10 all completions seen", q.size(), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule